// File: doc/BRIEF.md
# Hot-Swap Power Supervisor

This block is the digital control core of a hot-insertion power controller for a plug-in card with four supply rails. Every input is synchronous: a good flag per rail from the threshold comparators, an overcurrent flag, a flag that shows the start-up timer has reached its threshold, an off request from the pin, an external reset input, and three register bits that arrive over a serial bus. The outputs are the switch enable, a timer discharge control, the power-good, bus-isolation, fault, reset and status LED outputs.

When all rails are good, power-good asserts. When any rail drops, power-good stays asserted through a filter window. The block never removes supply power just because power-good was lost. Overcurrent is masked until the start-up timer has completed after turn-on. A sustained overcurrent after that latches a fault, and the fault turns the switches off. Only an off-then-on cycle of the combined off request clears the latch. An undervoltage lockout input forces the switches off and returns all state to its reset values.

Top module: `hotswap_supervisor`

## Requirements
- R1: `pg_n_o` goes low in the cycle after all rail flags are sampled high, and stays low while they stay high.
- R2: `pg_n_o` returns high only after any rail flag has been low for PG_CYC consecutive sampled cycles. A shorter dropout leaves it low. PG_CYC is PG_DEGLITCH_NS at CLK_HZ.
- R3: Losing power-good does not change `switch_en_o`.
- R4: `bus_iso_o` is high, which isolates the data lines, whenever power-good is not asserted, and low while it is asserted.
- R5: `overcurrent_i` has no effect until `timer_done_i` has been sampled high after turn-on. Arming takes effect from the next cycle.
- R6: After arming, OC_CYC consecutive sampled cycles of overcurrent latch a fault. In the following cycle `fault_n_o` is low and `switch_en_o` is low. A shorter burst restarts the count.
- R7: A latched fault stays until the combined off request falls. It clears in the cycle after that falling edge.
- R8: The combined off request is `off_req_i` OR `reg_off_i`. Either source turns the switches off and clears a fault through an off-then-on cycle.
- R9: While the combined off request is high, `switch_en_o` is low and `timer_discharge_o` is high. Arming is lost, so masking restarts at the next turn-on.
- R10: `reset_n_o` is low when `ext_reset_n_i` is low, when power-good is not asserted, or when `reg_reset_i` is high.
- R11: `led_n_o` is low when `reset_n_o` is low or when `reg_led_i` is high.
- R12: While `uvlo_i` is high, `switch_en_o` is low. Each edge clears power-good, the fault latch, arming and both filters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uvlo_i | input | 1 | Undervoltage lockout, active high |
| rail_good_i | input | NUM_RAILS | Per-rail above-threshold flags |
| overcurrent_i | input | 1 | Overcurrent flag |
| timer_done_i | input | 1 | Start-up timer reached threshold |
| off_req_i | input | 1 | Off request from the pin, high = off |
| ext_reset_n_i | input | 1 | External reset request, active low |
| reg_reset_i | input | 1 | Register reset latch, high = hold reset |
| reg_led_i | input | 1 | Register LED latch, high = light LED |
| reg_off_i | input | 1 | Register off request, high = off |
| switch_en_o | output | 1 | Power switch enable |
| timer_discharge_o | output | 1 | Hold start-up timer discharged |
| pg_n_o | output | 1 | Power good, active low |
| bus_iso_o | output | 1 | Data line isolation enable |
| fault_n_o | output | 1 | Latched fault, active low |
| reset_n_o | output | 1 | Card reset, active low |
| led_n_o | output | 1 | Status LED drive, active low |

## Verification
The bench builds the block with CLK_HZ at 1 MHz. At that rate the power-good filter is 10 cycles and the overcurrent filter is 35 cycles. These short windows put both edges of each filter within a few dozen cycles: a dropout one cycle short of the window, a burst broken just before the fault, and the exact cycle the fault latches. The run stays short while still covering fault clearing through each off source, masking after re-arm, and lockout in the middle of a fault.

// File: rtl/hotswap_supervisor.sv
module hotswap_supervisor #(
  parameter int NUM_RAILS       = 4,
  parameter int CLK_HZ          = 50_000_000,
  parameter int PG_DEGLITCH_NS  = 10_000,
  parameter int OC_FILTER_NS    = 35_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 uvlo_i,
  input  logic [NUM_RAILS-1:0] rail_good_i,
  input  logic                 overcurrent_i,
  input  logic                 timer_done_i,
  input  logic                 off_req_i,
  input  logic                 ext_reset_n_i,
  input  logic                 reg_reset_i,
  input  logic                 reg_led_i,
  input  logic                 reg_off_i,
  output logic                 switch_en_o,
  output logic                 timer_discharge_o,
  output logic                 pg_n_o,
  output logic                 bus_iso_o,
  output logic                 fault_n_o,
  output logic                 reset_n_o,
  output logic                 led_n_o
);

  localparam longint PG_RAW = (longint'(CLK_HZ) * longint'(PG_DEGLITCH_NS)) / 64'd1_000_000_000;
  localparam longint OC_RAW = (longint'(CLK_HZ) * longint'(OC_FILTER_NS)) / 64'd1_000_000_000;
  localparam int PG_CYC = (PG_RAW < 1) ? 1 : int'(PG_RAW);
  localparam int OC_CYC = (OC_RAW < 1) ? 1 : int'(OC_RAW);
  localparam int PG_W   = $clog2(PG_CYC + 1);
  localparam int OC_W   = $clog2(OC_CYC + 1);
  localparam logic [PG_W-1:0] PG_LAST = PG_W'(PG_CYC - 1);
  localparam logic [OC_W-1:0] OC_LAST = OC_W'(OC_CYC - 1);

  logic            pg_q, fault_q, armed_q, off_q;
  logic [PG_W-1:0] dg_cnt;
  logic [OC_W-1:0] oc_cnt;

  wire all_good = &rail_good_i;
  wire off_eff  = off_req_i | reg_off_i;
  wire off_fall = off_q & ~off_eff;
  wire oc_qual  = overcurrent_i & armed_q & switch_en_o;

  assign switch_en_o       = ~off_eff & ~fault_q & ~uvlo_i;
  assign timer_discharge_o = ~switch_en_o;
  assign pg_n_o            = ~pg_q;
  assign bus_iso_o         = ~pg_q;
  assign fault_n_o         = ~fault_q;
  assign reset_n_o         = ext_reset_n_i & pg_q & ~reg_reset_i;
  assign led_n_o           = reset_n_o & ~reg_led_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0;
      dg_cnt <= '0;
    end else if (uvlo_i) begin
      pg_q <= 1'b0;
      dg_cnt <= '0;
    end else if (all_good) begin
      pg_q <= 1'b1;
      dg_cnt <= '0;
    end else if (dg_cnt == PG_LAST) begin
      pg_q <= 1'b0;
    end else begin
      dg_cnt <= dg_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      armed_q <= 1'b0;
      oc_cnt  <= '0;
      off_q   <= 1'b0;
    end else begin
      off_q <= off_eff;
      if (uvlo_i) begin
        fault_q <= 1'b0;
        armed_q <= 1'b0;
        oc_cnt  <= '0;
      end else begin
        if (off_fall)
          fault_q <= 1'b0;
        else if (oc_qual && oc_cnt == OC_LAST)
          fault_q <= 1'b1;

        if (off_eff || fault_q)
          armed_q <= 1'b0;
        else if (timer_done_i)
          armed_q <= 1'b1;

        if (!oc_qual)
          oc_cnt <= '0;
        else if (oc_cnt != OC_LAST)
          oc_cnt <= oc_cnt + 1'b1;
      end
    end
  end

  // R1
  pg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (all_good && !uvlo_i) |=> pg_q);

  // R2
  pg_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pg_q) && !$past(uvlo_i)) |-> $past(!all_good));

  // R5
  arm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(timer_done_i));

  // R6
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(overcurrent_i && armed_q));

  // R7
  fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !uvlo_i && !off_fall) |=> fault_q);

  // R12
  uvlo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_i |=> (!fault_q && !armed_q && !pg_q));

endmodule

// File: tb/hotswap_supervisor_tb_top.sv
module hotswap_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PGC = 10;
  localparam int OCC = 35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uvlo = 1'b0;
  logic [3:0] rails = 4'h0;
  logic oc = 1'b0, tdone = 1'b0, offr = 1'b1, ext_rn = 1'b1;
  logic rrst = 1'b0, rled = 1'b0, roff = 1'b0;
  logic sw, tdis, pgn, iso, fn, rn, ln;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hotswap_supervisor #(.NUM_RAILS(4), .CLK_HZ(1_000_000),
                       .PG_DEGLITCH_NS(10_000), .OC_FILTER_NS(35_000)) dut_i (
    .clk(clk), .rst_n(rst_n), .uvlo_i(uvlo), .rail_good_i(rails),
    .overcurrent_i(oc), .timer_done_i(tdone), .off_req_i(offr),
    .ext_reset_n_i(ext_rn), .reg_reset_i(rrst), .reg_led_i(rled), .reg_off_i(roff),
    .switch_en_o(sw), .timer_discharge_o(tdis), .pg_n_o(pgn), .bus_iso_o(iso),
    .fault_n_o(fn), .reset_n_o(rn), .led_n_o(ln));

  // behavioural reference state
  int m_pg, m_bad, m_fault, m_armed, m_run, m_prev_off;

  function automatic int m_off();
    return (offr || roff) ? 1 : 0;
  endfunction
  function automatic int m_sw();
    return (!m_off() && !m_fault && !uvlo) ? 1 : 0;
  endfunction
  function automatic int m_rn();
    return (ext_rn && m_pg && !rrst) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pg = 0; m_bad = 0; m_fault = 0; m_armed = 0; m_run = 0; m_prev_off = 0;
    end else begin
      int good, qual, sw_now, offn;
      good = (rails == 4'hF);
      offn = m_off();
      sw_now = m_sw();
      qual = oc && m_armed && sw_now;
      if (uvlo) begin
        m_pg = 0; m_bad = 0; m_fault = 0; m_armed = 0; m_run = 0;
      end else begin
        int nf, na;
        if (good) begin m_pg = 1; m_bad = 0; end
        else begin
          m_bad++;
          if (m_bad >= PGC) begin m_pg = 0; m_bad = PGC; end
        end
        nf = m_fault;
        if (m_prev_off && !offn) nf = 0;
        else if (qual && m_run + 1 >= OCC) nf = 1;
        na = m_armed;
        if (offn || m_fault) na = 0;
        else if (tdone) na = 1;
        m_run = qual ? m_run + 1 : 0;
        m_fault = nf;
        m_armed = na;
      end
      m_prev_off = offn;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    #1;
    chk("R1/R2 pg_n", pgn, !m_pg);
    chk("R4 bus_iso", iso, !m_pg);
    chk("R3/R6/R9 switch_en", sw, m_sw() != 0);
    chk("R9 timer_discharge", tdis, m_sw() == 0);
    chk("R6/R7 fault_n", fn, !m_fault);
    chk("R10 reset_n", rn, m_rn() != 0);
    chk("R11 led_n", ln, m_rn() != 0 && !rled);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look(input string tag, input logic act, input logic exp);
    #2;
    chk(tag, act, exp);
  endtask

  initial begin
    cyc(3);
    look("R10 reset state reset_n", rn, 1'b0);
    look("R9 reset state switch_en", sw, 1'b0);
    look("R4 reset state bus_iso", iso, 1'b1);
    rst_n = 1'b1;
    cyc(2);
    rails = 4'hF; offr = 1'b0;
    cyc(1);
    look("R9 on switch_en", sw, 1'b1);
    look("R1 pg_n low", pgn, 1'b0);
    look("R11 led off", ln, 1'b1);
    rails = 4'hB; cyc(PGC - 1); rails = 4'hF;
    look("R2 short dropout", pgn, 1'b0);
    cyc(3);
    rails = 4'h7; cyc(PGC);
    look("R2 long dropout", pgn, 1'b1);
    look("R3 switch kept", sw, 1'b1);
    look("R10 reset on pg loss", rn, 1'b0);
    rails = 4'hF; cyc(2);
    oc = 1'b1; cyc(OCC + 10); oc = 1'b0;
    look("R5 masked", fn, 1'b1);
    tdone = 1'b1; cyc(1); tdone = 1'b0;
    oc = 1'b1; cyc(OCC - 1); oc = 1'b0; cyc(1);
    look("R6 short burst", fn, 1'b1);
    oc = 1'b1; cyc(OCC - 1);
    look("R6 one short", fn, 1'b1);
    cyc(1); oc = 1'b0;
    look("R6 latched", fn, 1'b0);
    look("R6 switch off", sw, 1'b0);
    cyc(20);
    look("R7 held", fn, 1'b0);
    offr = 1'b1; cyc(2); offr = 1'b0; cyc(1);
    look("R7 cleared", fn, 1'b1);
    look("R7 switch back", sw, 1'b1);
    tdone = 1'b1; cyc(1); tdone = 1'b0;
    oc = 1'b1; cyc(OCC); oc = 1'b0;
    look("R6 second fault", fn, 1'b0);
    roff = 1'b1; cyc(1);
    look("R8 reg off", tdis, 1'b1);
    cyc(2); roff = 1'b0; cyc(1);
    look("R8 reg cycle clears", fn, 1'b1);
    oc = 1'b1; cyc(OCC + 5); oc = 1'b0;
    look("R9 re-masked", fn, 1'b1);
    ext_rn = 1'b0; cyc(1);
    look("R10 ext reset", rn, 1'b0);
    look("R11 led via reset", ln, 1'b0);
    ext_rn = 1'b1; rrst = 1'b1; cyc(1);
    look("R10 reg reset", rn, 1'b0);
    rrst = 1'b0; rled = 1'b1; cyc(1);
    look("R11 reg led", ln, 1'b0);
    look("R10 released", rn, 1'b1);
    rled = 1'b0;
    tdone = 1'b1; cyc(1); tdone = 1'b0;
    oc = 1'b1; cyc(OCC); oc = 1'b0;
    look("R6 third fault", fn, 1'b0);
    uvlo = 1'b1; cyc(1);
    look("R12 switch off", sw, 1'b0);
    cyc(1);
    look("R12 fault cleared", fn, 1'b1);
    look("R12 pg cleared", pgn, 1'b1);
    uvlo = 1'b0; cyc(2);
    oc = 1'b1; cyc(OCC + 3); oc = 1'b0;
    look("R12 arming cleared", fn, 1'b1);
    cyc(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule